// File: doc/BRIEF.md
# Processor Status Flag Unit

This block keeps the eight condition and mode flags of a small processor core in one register and decides, every clock, how they change. Flag updates come from four sources: the result of an ALU operation of a given class, a single-flag set or clear command, the entry into an interrupt, and a reload of the whole byte popped from the stack. When several are active together, a fixed precedence picks exactly one of them.

Next to the live flags the unit produces the byte that is written to the stack. In that byte the break position reflects the cause of the interrupt, while the stored break flag always reads zero. The core's decimal arithmetic leaves the zero, overflow and negative flags meaningless. The unit therefore tracks, per flag, whether the value was ever defined since reset. It raises an indication while any of those three is not defined. Only the interrupt-disable flag has a defined reset value.

Top module: `psr_flag_unit`

## Requirements
- R1: On reset, `status` is 8'h04 (interrupt-disable set, every other bit 0) and `flags_known` is 8'h14 (only the interrupt-disable and break positions defined).
- R2: Bit positions are C=0, Z=1, I=2, D=3, B=4, T=5, V=6, N=7. An ALU update of class 0 (binary add or subtract) sets C to `alu_carry`, Z to 1 exactly when `alu_result` is zero, V to `alu_ovf` and N to the result's top bit. Classes 5 to 7 change nothing.
- R3: An ALU update of class 1 (decimal add or subtract) sets C to `alu_carry`, leaves the values of Z, V and N as they were, and marks those three as undefined.
- R4: An ALU update of class 2 (data transfer) sets Z and N from `alu_result` and leaves C and V unchanged.
- R5: An ALU update of class 3 (shift or rotate) sets C to `alu_carry` and Z and N from `alu_result`, and leaves V unchanged.
- R6: An ALU update of class 4 (bit test) copies the top bit of `bit_operand` into N and the bit below it into V. It sets Z when `alu_result AND bit_operand` is zero and leaves C unchanged.
- R7: A command with `cmd_sel` 0, 1, 2 or 3 writes `cmd_set` into C, I, D or T. With `cmd_sel` 4, a clear zeroes V and a set is ignored. Codes 5 to 7 are ignored.
- R8: The break bit of `status` is always 0. `push_byte` equals `status` with bit 4 replaced by `push_brk`.
- R9: `irq_enter` sets I in the next cycle.
- R10: `pop_valid` loads `pop_byte` into all flags with B forced to 0, and marks every flag defined.
- R11: Precedence when sources coincide: reset, then stack reload, then interrupt entry, then ALU update, then command. Only the winning source acts in that cycle.
- R12: A flag written by any source becomes defined in `flags_known`. `zvn_invalid` is 1 whenever Z, V or N is undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alu_valid | input | 1 | ALU flag-update request |
| alu_op | input | 3 | Operation class of the ALU update |
| alu_result | input | RES_W | ALU result (accumulator value for bit test) |
| alu_carry | input | 1 | Carry or borrow out of the ALU |
| alu_ovf | input | 1 | Signed overflow from the ALU |
| bit_operand | input | RES_W | Memory operand of a bit test |
| cmd_valid | input | 1 | Single-flag command request |
| cmd_sel | input | 3 | Flag selected by the command |
| cmd_set | input | 1 | 1 sets, 0 clears the selected flag |
| irq_enter | input | 1 | Interrupt entry |
| push_brk | input | 1 | Current push stems from a break |
| pop_valid | input | 1 | Reload flags from the stack |
| pop_byte | input | 8 | Byte popped from the stack |
| status | output | 8 | Live flag register |
| push_byte | output | 8 | Flag byte to write to the stack |
| flags_known | output | 8 | Per-flag defined mask |
| zvn_invalid | output | 1 | Z, V or N undefined |

## Verification
The clocked properties assume that the inputs are stable and free of unknowns around each rising edge. They also assume that the request lines are sampled as plain single-cycle pulses. Within those, they allow several requests to be active together, so that precedence is exercised. The stimulus changes every input only on the falling edge and returns each request to zero unless the next step asserts it again. It drives coinciding requests on purpose only in the steps aimed at precedence.

// File: rtl/psr_pkg.sv
`timescale 1ns/1ps
package psr_pkg;

   localparam int unsigned PSR_W = 8;

   // Flag positions inside the status byte
   localparam int unsigned FC = 0;
   localparam int unsigned FZ = 1;
   localparam int unsigned FI = 2;
   localparam int unsigned FD = 3;
   localparam int unsigned FB = 4;
   localparam int unsigned FT = 5;
   localparam int unsigned FV = 6;
   localparam int unsigned FN = 7;

   typedef logic [PSR_W-1:0] psr_t;

   typedef enum logic [2:0] {
      OPC_BIN   = 3'd0,
      OPC_DEC   = 3'd1,
      OPC_MOVE  = 3'd2,
      OPC_SHIFT = 3'd3,
      OPC_BTEST = 3'd4
   } op_class_e;

   typedef enum logic [2:0] {
      SEL_C = 3'd0,
      SEL_I = 3'd1,
      SEL_D = 3'd2,
      SEL_T = 3'd3,
      SEL_V = 3'd4
   } cmd_sel_e;

   typedef struct packed {
      psr_t value;
      psr_t known;
   } psr_upd_t;

   function automatic psr_t bit_of(input int unsigned idx);
      return psr_t'(1) << idx;
   endfunction

endpackage

// File: rtl/psr_alu_flags.sv
`timescale 1ns/1ps
module psr_alu_flags
   import psr_pkg::*;
#(
   parameter int unsigned RES_W        = 8,
   parameter bit          DEC_HOLD_ZVN = 1'b1
) (
   input  logic [2:0]       op,
   input  logic [RES_W-1:0] result,
   input  logic             carry,
   input  logic             ovf,
   input  logic [RES_W-1:0] operand,
   input  psr_t             cur,
   input  psr_t             cur_known,
   output psr_upd_t         upd
);

   localparam int unsigned MSB  = RES_W - 1;
   localparam int unsigned MSB1 = RES_W - 2;

   logic res_zero;
   logic res_neg;
   logic bt_zero;
   logic dec_z;
   logic dec_v;
   logic dec_n;

   assign res_zero = ~|result;
   assign res_neg  = result[MSB];
   assign bt_zero  = ~|(result & operand);

   // Decimal arithmetic: either keep the old Z/V/N values or let the raw
   // binary indications through; in both cases they are marked undefined.
   generate
      if (DEC_HOLD_ZVN) begin : g_dec_hold
         assign dec_z = cur[FZ];
         assign dec_v = cur[FV];
         assign dec_n = cur[FN];
      end else begin : g_dec_raw
         assign dec_z = res_zero;
         assign dec_v = ovf;
         assign dec_n = res_neg;
      end
   endgenerate

   always_comb begin
      upd.value = cur;
      upd.known = cur_known;
      case (op_class_e'(op))
         OPC_BIN: begin
            upd.value[FC] = carry;
            upd.value[FZ] = res_zero;
            upd.value[FV] = ovf;
            upd.value[FN] = res_neg;
            upd.known     = cur_known | bit_of(FC) | bit_of(FZ) | bit_of(FV) | bit_of(FN);
         end
         OPC_DEC: begin
            upd.value[FC] = carry;
            upd.value[FZ] = dec_z;
            upd.value[FV] = dec_v;
            upd.value[FN] = dec_n;
            upd.known     = (cur_known | bit_of(FC)) & ~(bit_of(FZ) | bit_of(FV) | bit_of(FN));
         end
         OPC_MOVE: begin
            upd.value[FZ] = res_zero;
            upd.value[FN] = res_neg;
            upd.known     = cur_known | bit_of(FZ) | bit_of(FN);
         end
         OPC_SHIFT: begin
            upd.value[FC] = carry;
            upd.value[FZ] = res_zero;
            upd.value[FN] = res_neg;
            upd.known     = cur_known | bit_of(FC) | bit_of(FZ) | bit_of(FN);
         end
         OPC_BTEST: begin
            upd.value[FZ] = bt_zero;
            upd.value[FV] = operand[MSB1];
            upd.value[FN] = operand[MSB];
            upd.known     = cur_known | bit_of(FZ) | bit_of(FV) | bit_of(FN);
         end
         default: begin
            upd.value = cur;
            upd.known = cur_known;
         end
      endcase
   end

endmodule

// File: rtl/psr_cmd_unit.sv
`timescale 1ns/1ps
module psr_cmd_unit
   import psr_pkg::*;
(
   input  logic [2:0] sel,
   input  logic       set_val,
   input  psr_t       cur,
   input  psr_t       cur_known,
   output psr_upd_t   upd
);

   always_comb begin
      upd.value = cur;
      upd.known = cur_known;
      case (cmd_sel_e'(sel))
         SEL_C: begin
            upd.value[FC] = set_val;
            upd.known[FC] = 1'b1;
         end
         SEL_I: begin
            upd.value[FI] = set_val;
            upd.known[FI] = 1'b1;
         end
         SEL_D: begin
            upd.value[FD] = set_val;
            upd.known[FD] = 1'b1;
         end
         SEL_T: begin
            upd.value[FT] = set_val;
            upd.known[FT] = 1'b1;
         end
         SEL_V: begin
            // overflow can only be cleared by command
            if (!set_val) begin
               upd.value[FV] = 1'b0;
               upd.known[FV] = 1'b1;
            end
         end
         default: begin
            upd.value = cur;
            upd.known = cur_known;
         end
      endcase
   end

endmodule

// File: rtl/psr_push_former.sv
`timescale 1ns/1ps
module psr_push_former
   import psr_pkg::*;
(
   input  psr_t status,
   input  logic brk,
   output psr_t push_byte
);

   generate
      for (genvar gi = 0; gi < PSR_W; gi++) begin : g_bit
         if (gi == FB) begin : g_brk
            assign push_byte[gi] = brk;
         end else begin : g_copy
            assign push_byte[gi] = status[gi];
         end
      end
   endgenerate

endmodule

// File: rtl/psr_flag_unit.sv
`timescale 1ns/1ps
module psr_flag_unit
   import psr_pkg::*;
#(
   parameter int unsigned RES_W        = 8,
   parameter bit          DEC_HOLD_ZVN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alu_valid,
   input  logic [2:0]       alu_op,
   input  logic [RES_W-1:0] alu_result,
   input  logic             alu_carry,
   input  logic             alu_ovf,
   input  logic [RES_W-1:0] bit_operand,
   input  logic             cmd_valid,
   input  logic [2:0]       cmd_sel,
   input  logic             cmd_set,
   input  logic             irq_enter,
   input  logic             push_brk,
   input  logic             pop_valid,
   input  logic [7:0]       pop_byte,
   output logic [7:0]       status,
   output logic [7:0]       push_byte,
   output logic [7:0]       flags_known,
   output logic             zvn_invalid
);

   localparam psr_t RST_VALUE = bit_of(FI);
   localparam psr_t RST_KNOWN = bit_of(FI) | bit_of(FB);
   localparam psr_t B_MASK    = bit_of(FB);
   localparam psr_t ZVN_MASK  = bit_of(FZ) | bit_of(FV) | bit_of(FN);

   initial begin : chk_params
      if (RES_W < 2) $error("psr_flag_unit: RES_W must be at least 2");
   end

   psr_t     status_q;
   psr_t     known_q;
   psr_upd_t alu_upd;
   psr_upd_t cmd_upd;
   psr_upd_t nxt;

   psr_alu_flags #(
      .RES_W        (RES_W),
      .DEC_HOLD_ZVN (DEC_HOLD_ZVN)
   ) alu_flags_i (
      .op        (alu_op),
      .result    (alu_result),
      .carry     (alu_carry),
      .ovf       (alu_ovf),
      .operand   (bit_operand),
      .cur       (status_q),
      .cur_known (known_q),
      .upd       (alu_upd)
   );

   psr_cmd_unit cmd_unit_i (
      .sel       (cmd_sel),
      .set_val   (cmd_set),
      .cur       (status_q),
      .cur_known (known_q),
      .upd       (cmd_upd)
   );

   psr_push_former push_former_i (
      .status    (status_q),
      .brk       (push_brk),
      .push_byte (push_byte)
   );

   // Source selection: stack reload, interrupt entry, ALU, command
   always_comb begin
      nxt.value = status_q;
      nxt.known = known_q;
      if (pop_valid) begin
         nxt.value = pop_byte & ~B_MASK;
         nxt.known = '1;
      end else if (irq_enter) begin
         nxt.value = status_q | bit_of(FI);
         nxt.known = known_q  | bit_of(FI);
      end else if (alu_valid) begin
         nxt = alu_upd;
      end else if (cmd_valid) begin
         nxt = cmd_upd;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= RST_VALUE;
         known_q  <= RST_KNOWN;
      end else begin
         status_q <= nxt.value;
         known_q  <= nxt.known;
      end
   end

   assign status      = status_q;
   assign flags_known = known_q;
   assign zvn_invalid = (known_q & ZVN_MASK) != ZVN_MASK;

   // R8: stored break flag never reads 1
   a_r8_break_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      status[FB] == 1'b0);

   // R8: pushed byte carries the break cause in bit 4, other bits from status
   a_r8_push_matches: assert property (@(posedge clk) disable iff (!rst_n)
      ((push_byte & ~B_MASK) == (status & ~B_MASK)) && (push_byte[FB] == push_brk));

   // R10: reload takes the popped byte minus break, all flags defined
   a_r10_pop_load: assert property (@(posedge clk) disable iff (!rst_n)
      pop_valid |=> (status == ($past(pop_byte) & ~B_MASK)) && (flags_known == 8'hFF));

   // R9: interrupt entry raises I
   a_r9_irq_sets_i: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_enter && !pop_valid) |=> status[FI]);

   // R11: interrupt entry leaves every other flag alone even with ALU active
   a_r11_irq_over_alu: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_enter && !pop_valid) |=> ((status & ~bit_of(FI)) == ($past(status) & ~bit_of(FI))));

   // R6: bit test copies the two top operand bits into N and V
   a_r6_bittest_nv: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_valid && alu_op == 3'd4 && !pop_valid && !irq_enter) |=>
         (status[FN] == $past(bit_operand[RES_W-1])) && (status[FV] == $past(bit_operand[RES_W-2])));

   // R3: decimal arithmetic leaves Z, V, N undefined
   a_r3_dec_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_valid && alu_op == 3'd1 && !pop_valid && !irq_enter) |=> zvn_invalid);

   // R7: a set command aimed at V changes nothing
   a_r7_v_set_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_sel == 3'd4 && cmd_set && !alu_valid && !pop_valid && !irq_enter) |=>
         ($stable(status) && $stable(flags_known)));

endmodule

// File: tb/psr_flag_unit_tb_top.sv
`timescale 1ns/1ps
module psr_flag_unit_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       alu_valid = 1'b0;
   logic [2:0] alu_op = '0;
   logic [7:0] alu_result = '0;
   logic       alu_carry = 1'b0;
   logic       alu_ovf = 1'b0;
   logic [7:0] bit_operand = '0;
   logic       cmd_valid = 1'b0;
   logic [2:0] cmd_sel = '0;
   logic       cmd_set = 1'b0;
   logic       irq_enter = 1'b0;
   logic       push_brk = 1'b0;
   logic       pop_valid = 1'b0;
   logic [7:0] pop_byte = '0;
   logic [7:0] status;
   logic [7:0] push_byte;
   logic [7:0] flags_known;
   logic       zvn_invalid;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // scoreboard
   logic [7:0] q_st[$];
   logic [7:0] q_kn[$];
   string      q_tag[$];

   logic [7:0] m_st;
   logic [7:0] m_kn;

   always #2 clk = ~clk;

   psr_flag_unit dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .alu_valid   (alu_valid),
      .alu_op      (alu_op),
      .alu_result  (alu_result),
      .alu_carry   (alu_carry),
      .alu_ovf     (alu_ovf),
      .bit_operand (bit_operand),
      .cmd_valid   (cmd_valid),
      .cmd_sel     (cmd_sel),
      .cmd_set     (cmd_set),
      .irq_enter   (irq_enter),
      .push_brk    (push_brk),
      .pop_valid   (pop_valid),
      .pop_byte    (pop_byte),
      .status      (status),
      .push_byte   (push_byte),
      .flags_known (flags_known),
      .zvn_invalid (zvn_invalid)
   );

   task automatic check8(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   // monitor: one registered result per driven step
   always @(posedge clk) begin
      #1;
      if (rst_n && q_st.size() > 0) begin
         logic [7:0] es;
         logic [7:0] ek;
         string      tg;
         es = q_st.pop_front();
         ek = q_kn.pop_front();
         tg = q_tag.pop_front();
         check8(tg, "status", status, es);
         check8(tg, "flags_known", flags_known, ek);
         check8(tg, "zvn_invalid", {7'd0, zvn_invalid}, {7'd0, ~(ek[1] & ek[6] & ek[7])});
      end
   end

   task automatic clear_inputs();
      alu_valid = 1'b0; alu_op = '0; alu_result = '0; alu_carry = 1'b0; alu_ovf = 1'b0;
      bit_operand = '0; cmd_valid = 1'b0; cmd_sel = '0; cmd_set = 1'b0;
      irq_enter = 1'b0; push_brk = 1'b0; pop_valid = 1'b0; pop_byte = '0;
   endtask

   // expected next state from the requirements, then queue it
   task automatic commit(input string tag);
      logic [7:0] ns;
      logic [7:0] nk;
      ns = m_st;
      nk = m_kn;
      #1;
      check8("R8", "push_byte", push_byte, (m_st & 8'hEF) | {3'b000, push_brk, 4'b0000});
      if (pop_valid) begin
         ns = pop_byte & 8'hEF; nk = 8'hFF;
      end else if (irq_enter) begin
         ns[2] = 1'b1; nk[2] = 1'b1;
      end else if (alu_valid) begin
         case (alu_op)
            3'd0: begin ns[0] = alu_carry; ns[1] = (alu_result == 8'h00); ns[6] = alu_ovf; ns[7] = alu_result[7]; nk = nk | 8'hC3; end
            3'd1: begin ns[0] = alu_carry; nk[0] = 1'b1; nk[1] = 1'b0; nk[6] = 1'b0; nk[7] = 1'b0; end
            3'd2: begin ns[1] = (alu_result == 8'h00); ns[7] = alu_result[7]; nk = nk | 8'h82; end
            3'd3: begin ns[0] = alu_carry; ns[1] = (alu_result == 8'h00); ns[7] = alu_result[7]; nk = nk | 8'h83; end
            3'd4: begin ns[1] = ((alu_result & bit_operand) == 8'h00); ns[6] = bit_operand[6]; ns[7] = bit_operand[7]; nk = nk | 8'hC2; end
            default: ;
         endcase
      end else if (cmd_valid) begin
         case (cmd_sel)
            3'd0: begin ns[0] = cmd_set; nk[0] = 1'b1; end
            3'd1: begin ns[2] = cmd_set; nk[2] = 1'b1; end
            3'd2: begin ns[3] = cmd_set; nk[3] = 1'b1; end
            3'd3: begin ns[5] = cmd_set; nk[5] = 1'b1; end
            3'd4: if (!cmd_set) begin ns[6] = 1'b0; nk[6] = 1'b1; end
            default: ;
         endcase
      end
      q_st.push_back(ns);
      q_kn.push_back(nk);
      q_tag.push_back(tag);
      m_st = ns;
      m_kn = nk;
   endtask

   task automatic do_alu(input logic [2:0] op, input logic [7:0] res, input logic c, input logic v,
                         input logic [7:0] opnd, input string tag);
      @(negedge clk);
      clear_inputs();
      alu_valid = 1'b1; alu_op = op; alu_result = res; alu_carry = c; alu_ovf = v; bit_operand = opnd;
      commit(tag);
   endtask

   task automatic do_cmd(input logic [2:0] sel, input logic set, input string tag);
      @(negedge clk);
      clear_inputs();
      cmd_valid = 1'b1; cmd_sel = sel; cmd_set = set;
      commit(tag);
   endtask

   task automatic do_idle(input logic brk, input string tag);
      @(negedge clk);
      clear_inputs();
      push_brk = brk;
      commit(tag);
   endtask

   initial begin
      clear_inputs();
      repeat (3) @(negedge clk);
      #1;
      // R1: reset values while reset is held
      check8("R1", "status", status, 8'h04);
      check8("R1", "flags_known", flags_known, 8'h14);
      check8("R1", "zvn_invalid", {7'd0, zvn_invalid}, 8'h01);
      @(negedge clk);
      rst_n = 1'b1;
      m_st = 8'h04;
      m_kn = 8'h14;

      // R7: commands on C, I, D, T
      do_cmd(3'd0, 1'b1, "R7");
      do_cmd(3'd2, 1'b1, "R7");
      do_cmd(3'd3, 1'b1, "R7");
      do_cmd(3'd1, 1'b0, "R7");
      do_cmd(3'd0, 1'b0, "R7");
      // R2: binary arithmetic
      do_alu(3'd0, 8'h00, 1'b1, 1'b0, 8'h00, "R2");
      do_alu(3'd0, 8'h80, 1'b0, 1'b1, 8'h00, "R2");
      do_alu(3'd0, 8'h35, 1'b1, 1'b0, 8'h00, "R2");
      do_alu(3'd6, 8'h00, 1'b0, 1'b1, 8'hFF, "R2");
      // R3: decimal arithmetic
      do_alu(3'd0, 8'h80, 1'b0, 1'b1, 8'h00, "R2");
      do_alu(3'd1, 8'h00, 1'b1, 1'b0, 8'h00, "R3");
      // R12: transfer defines Z and N only, V stays undefined
      do_alu(3'd2, 8'h00, 1'b0, 1'b0, 8'h00, "R12");
      // R4: transfer of a negative value, C and V unchanged
      do_alu(3'd2, 8'hF0, 1'b0, 1'b1, 8'h00, "R4");
      do_alu(3'd0, 8'h01, 1'b0, 1'b0, 8'h00, "R12");
      // R5: shift / rotate
      do_alu(3'd3, 8'h80, 1'b1, 1'b0, 8'h00, "R5");
      do_alu(3'd3, 8'h00, 1'b0, 1'b1, 8'h00, "R5");
      // R6: bit test
      do_alu(3'd4, 8'h0F, 1'b1, 1'b0, 8'hC0, "R6");
      do_alu(3'd4, 8'h01, 1'b0, 1'b0, 8'h41, "R6");
      do_alu(3'd4, 8'hFF, 1'b0, 1'b0, 8'h00, "R6");
      // R7: V set ignored, V clear, unused code ignored
      do_alu(3'd4, 8'h01, 1'b0, 1'b0, 8'h41, "R6");
      do_cmd(3'd4, 1'b1, "R7");
      do_cmd(3'd6, 1'b1, "R7");
      do_cmd(3'd4, 1'b0, "R7");
      // R8: pushed byte with and without break cause
      do_idle(1'b1, "R8");
      do_idle(1'b0, "R8");
      // R9: interrupt entry
      do_cmd(3'd1, 1'b0, "R9");
      @(negedge clk); clear_inputs(); irq_enter = 1'b1; push_brk = 1'b1; commit("R9");
      // R10: stack reload, break bit dropped
      @(negedge clk); clear_inputs(); pop_valid = 1'b1; pop_byte = 8'hFF; commit("R10");
      @(negedge clk); clear_inputs(); pop_valid = 1'b1; pop_byte = 8'h10; commit("R10");
      // R11: coinciding sources
      @(negedge clk); clear_inputs(); pop_valid = 1'b1; pop_byte = 8'h81; irq_enter = 1'b1; commit("R11");
      @(negedge clk); clear_inputs(); irq_enter = 1'b1; alu_valid = 1'b1; alu_op = 3'd0;
      alu_result = 8'h00; alu_carry = 1'b0; commit("R11");
      @(negedge clk); clear_inputs(); alu_valid = 1'b1; alu_op = 3'd2; alu_result = 8'h00;
      cmd_valid = 1'b1; cmd_sel = 3'd2; cmd_set = 1'b1; commit("R11");
      @(negedge clk); clear_inputs(); pop_valid = 1'b1; pop_byte = 8'h00; cmd_valid = 1'b1;
      cmd_sel = 3'd0; cmd_set = 1'b1; commit("R11");
      do_idle(1'b0, "R11");

      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      #20000;
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, got timeout expected finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule